// File: doc/BRIEF.md
# Four-Word Burst Separate-I/O SRAM Core

This block is a synthesizable behavioural model of a quad-data-rate style synchronous SRAM. It has a dedicated write-data port and a dedicated read-data port, so neither needs a turnaround cycle and a read and a write can run at the same time. A single address bus carries both kinds of command. One internal clock runs at twice the input-clock rate. A phase bit marks each rising edge as either a true-clock (K) edge or a complemented-clock (K-bar) edge. Read addresses are taken on K edges and write addresses on K-bar edges.

Each burst address names four consecutive words, at burst address A times four plus offsets 0, 1, 2 and 3. A burst moves one word per edge, which is two input-clock cycles for a full burst. Each write word has its own byte enables. A read always returns the newest data. Bytes of a write burst that are still waiting in the write buffer are forwarded into the read data one byte at a time. A static mode input selects one of two read latencies: 1.5 input cycles or 1 input cycle. The storage contents are not cleared by reset.

Top module: `burst4_sram`

## Requirements
- R1: `kbar_slot` is 0 during reset and after it, and it inverts on every `clk` edge. The first edge after reset release is a K edge. An edge is a K-bar edge when `kbar_slot` was 1 before it.
- R2: A read command is accepted when `rd_sel_n` is 0 on a K edge, and `addr` is taken as the read burst address. A low `rd_sel_n` on a K-bar edge is ignored.
- R3: A write command is accepted when `wr_sel_n` is 0 on a K-bar edge, and `addr` is taken as the write burst address. A low `wr_sel_n` on a K edge is ignored.
- R4: After an accepted read, read selects on the next three edges are ignored. After an accepted write, write selects on the next three edges are ignored.
- R5: For a write accepted at edge T, `wr_data` is sampled on edges T+1 to T+4 as words 0 to 3 of the burst. Word i of burst address A is storage word 4*A+i.
- R6: `wr_be` bit b set to 1 writes bits [b*BYTE_W +: BYTE_W] of the word. When bit b is 0, that byte keeps its old contents.
- R7: For a read accepted at edge T, word 0 is on `rd_data` after edge T+3 when `lat_full` is 1, and after edge T+2 when `lat_full` is 0. Words 1 to 3 follow on the next three edges. `lat_full` changes only while `rst_n` is 0.
- R8: `rd_valid` is 1 on exactly the four edges of each read burst. `rd_data` is 0 whenever `rd_valid` is 0.
- R9: A read word shows every write byte sampled at or before the edge that loads that word. This includes bytes of a write burst that has not yet finished.
- R10: While `rst_n` is 0, `rd_valid` and `rd_data` are 0, and no command or burst in progress survives reset.
- R11: Read bursts and write bursts to any addresses can overlap in time without affecting each other's sequencing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; one rising edge per input-clock edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lat_full | input | 1 | 1: 1.5-cycle read latency, 0: 1-cycle read latency |
| rd_sel_n | input | 1 | Active-low read select, sampled on K edges |
| wr_sel_n | input | 1 | Active-low write select, sampled on K-bar edges |
| addr | input | ADDR_W | Shared burst address bus |
| wr_data | input | BYTES*BYTE_W | Write data word for the current beat |
| wr_be | input | BYTES | Per-byte write enables for the current beat |
| rd_data | output | BYTES*BYTE_W | Read data word, 0 when idle |
| rd_valid | output | 1 | High while `rd_data` carries a burst word |
| kbar_slot | output | 1 | 1 when the next edge is a K-bar edge |

## Verification
First, every burst address is filled with full-mask writes, and then it is read back in both latency modes. This separates the burst word order from the beat timing. Partial byte masks written over known data show whether masked bytes are kept. Two directed overlaps target the same address: a read issued one edge after a write, and a write issued one edge after a read. These show whether data is forwarded from the pending buffer, from the live beat, or from storage. Random traffic over four addresses then drives selects on the wrong phase and selects that come too soon, which separates the acceptance rules from the data path.

// File: rtl/b4s_pkg.sv
package b4s_pkg;
   localparam int BURST = 4;
   localparam int IDX_W = 2;
   localparam int GAP   = BURST - 1;

   typedef enum logic {
      EDGE_K  = 1'b0,
      EDGE_KB = 1'b1
   } edge_t;
endpackage

// File: rtl/b4s_rd_seq.sv
module b4s_rd_seq
   import b4s_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  edge_t               edge_kind,
   input  logic                sel_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                lat_full,
   output logic                fire,
   output logic [ADDR_W-1:0]   beat_addr,
   output logic [IDX_W-1:0]    beat_idx
);
   localparam int STAGES = 3;

   logic                accept;
   logic [1:0]          gap_q;
   logic [STAGES-1:0]   stg_vld;
   logic [ADDR_W-1:0]   stg_addr [STAGES];
   logic                start;
   logic [ADDR_W-1:0]   start_addr;
   logic                seq_act;
   logic [IDX_W-1:0]    seq_idx;
   logic [ADDR_W-1:0]   seq_addr;

   assign accept = !sel_n && (edge_kind == EDGE_K) && (gap_q == 2'd0);

   always_ff @(posedge clk) begin
      if (!rst_n)          gap_q <= 2'd0;
      else if (accept)     gap_q <= 2'(GAP);
      else if (gap_q != 0) gap_q <= gap_q - 2'd1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stg_vld[0] <= 1'b0;
      else        stg_vld[0] <= accept;
      stg_addr[0] <= addr;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stg_vld[s] <= 1'b0;
         else        stg_vld[s] <= stg_vld[s-1];
         stg_addr[s] <= stg_addr[s-1];
      end
   end

   assign start      = lat_full ? stg_vld[2]  : stg_vld[1];
   assign start_addr = lat_full ? stg_addr[2] : stg_addr[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seq_act <= 1'b0;
         seq_idx <= '0;
      end else if (start) begin
         seq_act <= 1'b1;
         seq_idx <= IDX_W'(1);
      end else if (seq_act) begin
         seq_idx <= seq_idx + IDX_W'(1);
         if (seq_idx == IDX_W'(BURST - 1)) seq_act <= 1'b0;
      end
      if (start) seq_addr <= start_addr;
   end

   assign fire      = start | seq_act;
   assign beat_addr = start ? start_addr : seq_addr;
   assign beat_idx  = start ? '0 : seq_idx;

   a_r4_rd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !accept ##1 !accept ##1 !accept);

   a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !seq_act);

   a_r7_lat_full: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && lat_full) |-> ##3 start);

   a_r7_lat_one: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !lat_full) |-> ##2 start);
endmodule

// File: rtl/b4s_wr_buf.sv
module b4s_wr_buf
   import b4s_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int BYTES  = 2,
   parameter int DW     = 18
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  edge_t                          edge_kind,
   input  logic                           sel_n,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [DW-1:0]                  wdata,
   input  logic [BYTES-1:0]               wbe,
   output logic                           act,
   output logic [IDX_W-1:0]               idx,
   output logic [ADDR_W-1:0]              waddr,
   output logic [BURST-1:0][DW-1:0]       pend_word,
   output logic [BURST-1:0][BYTES-1:0]    pend_be,
   output logic [BURST-1:0]               pend_vld,
   output logic                           commit,
   output logic [BURST-1:0][DW-1:0]       commit_word,
   output logic [BURST-1:0][BYTES-1:0]    commit_be
);
   logic       accept;
   logic [1:0] gap_q;

   assign accept = !sel_n && (edge_kind == EDGE_KB) && (gap_q == 2'd0);

   always_ff @(posedge clk) begin
      if (!rst_n)          gap_q <= 2'd0;
      else if (accept)     gap_q <= 2'(GAP);
      else if (gap_q != 0) gap_q <= gap_q - 2'd1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act      <= 1'b0;
         idx      <= '0;
         pend_vld <= '0;
      end else begin
         if (act) begin
            pend_word[idx] <= wdata;
            pend_be[idx]   <= wbe;
            pend_vld[idx]  <= 1'b1;
            idx            <= idx + IDX_W'(1);
            if (idx == IDX_W'(BURST - 1)) begin
               act      <= 1'b0;
               pend_vld <= '0;
            end
         end
         if (accept) begin
            act   <= 1'b1;
            idx   <= '0;
            waddr <= addr;
         end
      end
   end

   assign commit = act && (idx == IDX_W'(BURST - 1));

   for (genvar w = 0; w < BURST; w++) begin : g_commit
      if (w == BURST - 1) begin : g_live
         assign commit_word[w] = wdata;
         assign commit_be[w]   = wbe;
      end else begin : g_held
         assign commit_word[w] = pend_word[w];
         assign commit_be[w]   = pend_be[w];
      end
   end

   a_r4_wr_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !accept ##1 !accept ##1 !accept);

   a_r5_commit_after_beats: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> ($past(act) && $past(act, 2) && $past(act, 3)));

   a_r5_commit_all_pending: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (pend_vld == BURST'((1 << (BURST - 1)) - 1)));
endmodule

// File: rtl/b4s_store.sv
module b4s_store
   import b4s_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int BYTES  = 2,
   parameter int BYTE_W = 9
) (
   input  logic                                   clk,
   input  logic                                   we,
   input  logic [ADDR_W-1:0]                      waddr,
   input  logic [BURST-1:0][BYTES*BYTE_W-1:0]     wword,
   input  logic [BURST-1:0][BYTES-1:0]            wbe,
   input  logic [ADDR_W-1:0]                      raddr,
   output logic [BURST-1:0][BYTES*BYTE_W-1:0]     rword
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int DW    = BYTES * BYTE_W;

   for (genvar l = 0; l < BURST; l++) begin : g_lane
      logic [DW-1:0] mem [DEPTH];

      for (genvar b = 0; b < BYTES; b++) begin : g_byte
         always_ff @(posedge clk) begin
            if (we && wbe[l][b])
               mem[waddr][b*BYTE_W +: BYTE_W] <= wword[l][b*BYTE_W +: BYTE_W];
         end
      end

      assign rword[l] = mem[raddr];
   end
endmodule

// File: rtl/burst4_sram.sv
module burst4_sram
   import b4s_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int BYTE_W = 9,
   parameter int BYTES  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      lat_full,
   input  logic                      rd_sel_n,
   input  logic                      wr_sel_n,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [BYTES*BYTE_W-1:0]   wr_data,
   input  logic [BYTES-1:0]          wr_be,
   output logic [BYTES*BYTE_W-1:0]   rd_data,
   output logic                      rd_valid,
   output logic                      kbar_slot
);
   localparam int DW = BYTES * BYTE_W;

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 10) else $error("ADDR_W out of range");
      assert (BYTES >= 1 && BYTES <= 8)    else $error("BYTES out of range");
      assert (BYTE_W >= 1)                 else $error("BYTE_W out of range");
   end

   logic  ph_q;
   edge_t cur_edge;

   always_ff @(posedge clk) begin
      if (!rst_n) ph_q <= 1'b0;
      else        ph_q <= ~ph_q;
   end

   assign cur_edge  = ph_q ? EDGE_KB : EDGE_K;
   assign kbar_slot = ph_q;

   logic                r_fire;
   logic [ADDR_W-1:0]   r_addr;
   logic [IDX_W-1:0]    r_idx;

   b4s_rd_seq #(.ADDR_W(ADDR_W)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .edge_kind (cur_edge),
      .sel_n     (rd_sel_n),
      .addr      (addr),
      .lat_full  (lat_full),
      .fire      (r_fire),
      .beat_addr (r_addr),
      .beat_idx  (r_idx)
   );

   logic                          w_act;
   logic [IDX_W-1:0]              w_idx;
   logic [ADDR_W-1:0]             w_addr;
   logic [BURST-1:0][DW-1:0]      p_word;
   logic [BURST-1:0][BYTES-1:0]   p_be;
   logic [BURST-1:0]              p_vld;
   logic                          c_en;
   logic [BURST-1:0][DW-1:0]      c_word;
   logic [BURST-1:0][BYTES-1:0]   c_be;

   b4s_wr_buf #(.ADDR_W(ADDR_W), .BYTES(BYTES), .DW(DW)) u_wr (
      .clk         (clk),
      .rst_n       (rst_n),
      .edge_kind   (cur_edge),
      .sel_n       (wr_sel_n),
      .addr        (addr),
      .wdata       (wr_data),
      .wbe         (wr_be),
      .act         (w_act),
      .idx         (w_idx),
      .waddr       (w_addr),
      .pend_word   (p_word),
      .pend_be     (p_be),
      .pend_vld    (p_vld),
      .commit      (c_en),
      .commit_word (c_word),
      .commit_be   (c_be)
   );

   logic [BURST-1:0][DW-1:0] s_word;

   b4s_store #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_store (
      .clk   (clk),
      .we    (c_en),
      .waddr (w_addr),
      .wword (c_word),
      .wbe   (c_be),
      .raddr (r_addr),
      .rword (s_word)
   );

   logic              same_addr;
   logic              live_hit;
   logic              pend_hit;
   logic [DW-1:0]     base_word;
   logic [DW-1:0]     pend_sel;
   logic [DW-1:0]     merged;

   assign same_addr = (w_addr == r_addr);
   assign live_hit  = w_act && (w_idx == r_idx) && same_addr;
   assign pend_hit  = p_vld[r_idx] && same_addr;
   assign base_word = s_word[r_idx];
   assign pend_sel  = p_word[r_idx];

   for (genvar b = 0; b < BYTES; b++) begin : g_fwd
      always_comb begin
         if (live_hit && wr_be[b])
            merged[b*BYTE_W +: BYTE_W] = wr_data[b*BYTE_W +: BYTE_W];
         else if (pend_hit && p_be[r_idx][b])
            merged[b*BYTE_W +: BYTE_W] = pend_sel[b*BYTE_W +: BYTE_W];
         else
            merged[b*BYTE_W +: BYTE_W] = base_word[b*BYTE_W +: BYTE_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= r_fire;
         rd_data  <= r_fire ? merged : '0;
      end
   end

   a_r8_four_beats: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> rd_valid ##1 rd_valid ##1 rd_valid ##1 rd_valid);

   a_r9_fwd_one_source: assert property (@(posedge clk) disable iff (!rst_n)
      (live_hit && pend_hit) |-> (w_idx != r_idx) || !p_vld[w_idx]);
endmodule

// File: tb/tb_burst4_sram.sv
`timescale 1ns/1ps
module tb_burst4_sram;
   localparam int AW = 4;
   localparam int BW = 9;
   localparam int NB = 2;
   localparam int DW = NB * BW;
   localparam int NWORDS = (1 << AW) * 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lat_full = 1'b1;
   logic          rd_sel_n = 1'b1;
   logic          wr_sel_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [NB-1:0] wr_be = '0;
   logic [DW-1:0] rd_data;
   logic          rd_valid;
   logic          kbar_slot;

   burst4_sram #(.ADDR_W(AW), .BYTE_W(BW), .BYTES(NB)) dut (
      .clk(clk), .rst_n(rst_n), .lat_full(lat_full),
      .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n), .addr(addr),
      .wr_data(wr_data), .wr_be(wr_be),
      .rd_data(rd_data), .rd_valid(rd_valid), .kbar_slot(kbar_slot)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int n = 0;
   string ctx = "R5";

   logic [DW-1:0] mm [NWORDS];
   int  rnext, wnext, wbeat, waddr;
   bit  wact;
   bit  sq_v [16];
   int  sq_a [16];
   int  sq_i [16];

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s at edge %0d: got %0h expected %0h", tag, what, n, act, exp);
      end
   endtask

   task automatic model_clear();
      n = 0; rnext = 0; wnext = 0; wact = 0; wbeat = 0;
      for (int i = 0; i < 16; i++) sq_v[i] = 0;
   endtask

   task automatic step(bit rs, bit ws, int a, logic [DW-1:0] d, logic [NB-1:0] be);
      bit            kslot;
      int            s;
      bit            expv;
      logic [DW-1:0] expd;
      rd_sel_n = rs; wr_sel_n = ws; addr = a[AW-1:0]; wr_data = d; wr_be = be;
      kslot = (n % 2 == 0);
      if (wact) begin
         for (int b = 0; b < NB; b++)
            if (be[b]) mm[waddr*4 + wbeat][b*BW +: BW] = d[b*BW +: BW];
         wbeat++;
         if (wbeat == 4) wact = 0;
      end
      if (!kslot && !ws && n >= wnext) begin
         wact = 1; wbeat = 0; waddr = a; wnext = n + 4;
      end
      if (kslot && !rs && n >= rnext) begin
         rnext = n + 4;
         for (int i = 0; i < 4; i++) begin
            s = (n + (lat_full ? 3 : 2) + i) % 16;
            sq_v[s] = 1; sq_a[s] = a; sq_i[s] = i;
         end
      end
      s = n % 16;
      if (sq_v[s]) begin
         expv = 1; expd = mm[sq_a[s]*4 + sq_i[s]]; sq_v[s] = 0;
      end else begin
         expv = 0; expd = '0;
      end
      @(posedge clk);
      @(negedge clk);
      chk("R8", {31'd0, rd_valid}, {31'd0, expv}, "rd_valid");
      chk(ctx, 32'(rd_data), 32'(expd), "rd_data");
      chk("R1", {31'd0, kbar_slot}, 32'((n + 1) % 2), "kbar_slot");
      n++;
   endtask

   task automatic idle(int cnt);
      for (int i = 0; i < cnt; i++) step(1, 1, $urandom % 16, DW'($urandom), NB'($urandom));
   endtask

   task automatic align(bit want_kbar);
      if ((n % 2 == 1) != want_kbar) idle(1);
   endtask

   task automatic do_reset(bit lat);
      rd_sel_n = 1; wr_sel_n = 1; rst_n = 0; lat_full = lat;
      repeat (3) @(negedge clk);
      chk("R10", {31'd0, rd_valid}, 32'd0, "rd_valid in reset");
      chk("R10", 32'(rd_data), 32'd0, "rd_data in reset");
      chk("R1", {31'd0, kbar_slot}, 32'd0, "kbar_slot in reset");
      rst_n = 1;
      model_clear();
   endtask

   task automatic write_burst(int a, logic [NB-1:0] mask);
      align(1);
      step(1, 0, a, DW'($urandom), '0);
      for (int i = 0; i < 4; i++) step(1, 1, $urandom % 16, DW'($urandom), mask);
   endtask

   task automatic read_burst(int a);
      align(0);
      step(0, 1, a, DW'($urandom), '0);
      idle(3);
   endtask

   task automatic random_phase(int cnt);
      for (int i = 0; i < cnt; i++)
         step(($urandom % 3) != 0, ($urandom % 3) != 0, $urandom % 4,
              DW'($urandom), NB'($urandom));
      idle(8);
   endtask

   task automatic coherency_pair();
      idle(4);
      align(1);
      step(1, 0, 5, DW'($urandom), '0);
      step(0, 1, 5, DW'($urandom), 2'b11);
      for (int i = 0; i < 3; i++) step(1, 1, 0, DW'($urandom), NB'($urandom));
      idle(6);
      align(0);
      step(0, 1, 6, DW'($urandom), '0);
      step(1, 0, 6, DW'($urandom), '0);
      for (int i = 0; i < 4; i++) step(1, 1, 0, DW'($urandom), NB'($urandom));
      idle(6);
      align(0);
      step(0, 1, 9, DW'($urandom), '0);
      step(1, 0, 9, DW'($urandom), '0);
      step(0, 1, 9, DW'($urandom), 2'b01);
      for (int i = 0; i < 3; i++) step(1, 1, 9, DW'($urandom), 2'b10);
      idle(8);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h0B17_4C5D));
      @(negedge clk);
      do_reset(1'b1);

      ctx = "R5";
      for (int a = 0; a < 16; a++) write_burst(a, 2'b11);
      ctx = "R7";
      for (int a = 0; a < 16; a++) read_burst(a);
      idle(6);

      ctx = "R6";
      write_burst(7, 2'b01);
      write_burst(7, 2'b10);
      write_burst(3, 2'b00);
      read_burst(7);
      read_burst(3);
      idle(6);

      ctx = "R9";
      coherency_pair();

      ctx = "R11";
      random_phase(1500);

      do_reset(1'b0);
      ctx = "R7";
      for (int a = 0; a < 16; a += 3) read_burst(a);
      idle(6);
      ctx = "R9";
      coherency_pair();
      ctx = "R4";
      random_phase(1500);
      ctx = "R2";
      for (int i = 0; i < 200; i++) step(0, 1, $urandom % 16, DW'($urandom), '0);
      idle(8);
      ctx = "R3";
      for (int i = 0; i < 200; i++) step(1, 0, $urandom % 16, DW'($urandom), NB'($urandom));
      idle(8);
      for (int a = 0; a < 16; a++) read_burst(a);
      idle(8);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule